// File: doc/BRIEF.md
# General-Purpose Register File with Pointer Address Generation

This block is the working register store of a small 8-bit RISC core: thirty-two 8-bit registers with two combinational operand read ports and one ALU write port, so a register-to-register operation reads both sources and retires its result in one clock. Three register pairs at the top of the file also serve as 16-bit data pointers, and an address generator built into the block turns each memory access request into a 16-bit effective address.

An access request carries a mode, a pointer select, a 6-bit displacement, a 16-bit immediate and a store flag. The block produces the effective address and a region code (register file, I/O, SRAM). For pre-decrement and post-increment modes it writes the updated pointer back into its pair on the same clock edge. An access whose address lands in the lowest 32 bytes is served by the register file itself: loads return the register, stores overwrite it. The Z pair is also split into a word address and a byte-select bit for program-memory byte fetches.

The core drives all inputs from its decode stage. The block holds no state beyond the 32 registers.

Top module: `gpr_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to 0x00 on the next rising edge, so both read ports then return 0x00.
- R2: Both read ports return the addressed register combinationally. An ALU write (`alu_we`) updates register `alu_widx` on the rising edge, and the new value is readable after that edge.
- R3: The pointers are X = {r27,r26}, Y = {r29,r28} and Z = {r31,r30}, with the low byte in the lower-numbered register. The pointer select codes are 0 for X, 1 for Y and 2 for Z. The mode codes are 0 for direct (`ea` = `acc_imm`), 1 for indirect (`ea` = pointer) and 2 for displacement (`ea` = pointer + unsigned `acc_disp`, 0..63).
- R4: Mode 3 (pre-decrement) gives `ea` = pointer − 1. Mode 4 (post-increment) gives `ea` = old pointer and writes pointer + 1. In both cases both bytes of the pair take the new value on the same edge, and arithmetic wraps modulo 2^16.
- R5: The following requests raise `acc_illegal`: displacement with X, pointer select 3 in modes 1 to 4, and mode codes 5 to 7. An illegal request changes no register, whether through pointer update or through a store.
- R6: `region` is 0 when `ea` is 0x0000..0x001F, 1 when `ea` is 0x0020..0x005F, and 2 when `ea` is 0x0060 or above.
- R7: For a legal valid access with region 0, `acc_rdata` returns register `ea[4:0]`, and a store (`acc_store`) writes `acc_wdata` to that register on the edge. In any other region `acc_rdata` is 0x00 and a store changes no register.
- R8: A pointer write-back beats a register-file store and an ALU write to the same register, and a register-file store beats an ALU write. `collision` is high in a cycle where a pointer write-back and an ALU write hit the same register.
- R9: `pm_word` equals Z[15:1] and `pm_hi` equals Z[0], both taken combinationally from the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 8 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 8 | Operand B value |
| alu_we | input | 1 | ALU result write enable |
| alu_widx | input | 5 | ALU result register index |
| alu_wdata | input | 8 | ALU result value |
| acc_valid | input | 1 | Data access request present |
| acc_mode | input | 3 | Addressing mode code |
| acc_ptr | input | 2 | Pointer select code |
| acc_disp | input | 6 | Unsigned displacement |
| acc_imm | input | 16 | Direct address |
| acc_store | input | 1 | Access is a store |
| acc_wdata | input | 8 | Store data |
| acc_rdata | output | 8 | Load data when served by the register file |
| ea | output | 16 | Effective data address |
| region | output | 2 | Address region code |
| acc_illegal | output | 1 | Request has an illegal mode/pointer combination |
| collision | output | 1 | Pointer write-back and ALU write hit one register |
| pm_word | output | 15 | Program-memory word address from Z |
| pm_hi | output | 1 | Program-memory high-byte select from Z |

## Verification
A pointer write-back and an ALU result write can both fall in the same cycle on the same register. The bench provokes this by issuing a post-increment through X while the ALU port writes r27. It judges the outcome by the `collision` flag, and afterwards by reading both pair bytes through the operand ports to confirm that they hold the incremented pointer and not the ALU value. Separate cases cover a register-file store that races an ALU write, and wrap-around at 0x0000 and 0xFFFF.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int NREG  = 32;
    localparam int IDXW  = $clog2(NREG);
    localparam int DW    = 8;
    localparam int AW    = 16;
    localparam int DISPW = 6;
    localparam logic [AW-1:0] IO_LIMIT = 16'h0060;

    typedef enum logic [2:0] {
        AM_DIRECT = 3'd0,
        AM_IND    = 3'd1,
        AM_DISP   = 3'd2,
        AM_PREDEC = 3'd3,
        AM_POSTINC= 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        PS_X = 2'd0,
        PS_Y = 2'd1,
        PS_Z = 2'd2
    } psel_e;

    typedef enum logic [1:0] {
        RG_FILE = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2
    } region_e;

    // low-byte register index of each pointer pair
    localparam logic [IDXW-1:0] X_LO = 5'd26;
    localparam logic [IDXW-1:0] Y_LO = 5'd28;
    localparam logic [IDXW-1:0] Z_LO = 5'd30;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] gpr;
    } rf_state_t;
endpackage

// File: rtl/gpr_addr_gen.sv
module gpr_addr_gen
    import gpr_pkg::*;
(
    input  logic [2:0]        mode,
    input  logic [1:0]        psel,
    input  logic [DISPW-1:0]  disp,
    input  logic [AW-1:0]     imm,
    input  logic [AW-1:0]     ptr_x,
    input  logic [AW-1:0]     ptr_y,
    input  logic [AW-1:0]     ptr_z,
    output logic [AW-1:0]     ea,
    output logic              wb_en,
    output logic [AW-1:0]     wb_val,
    output logic              illegal
);
    logic [AW-1:0] base;
    logic          bad_ptr;

    always_comb begin
        bad_ptr = 1'b0;
        unique case (psel)
            PS_X:    base = ptr_x;
            PS_Y:    base = ptr_y;
            PS_Z:    base = ptr_z;
            default: begin base = '0; bad_ptr = 1'b1; end
        endcase
    end

    always_comb begin
        ea      = '0;
        wb_en   = 1'b0;
        wb_val  = base;
        illegal = 1'b0;
        case (mode)
            AM_DIRECT: ea = imm;
            AM_IND: begin
                ea      = base;
                illegal = bad_ptr;
            end
            AM_DISP: begin
                ea      = base + {{(AW-DISPW){1'b0}}, disp};
                illegal = bad_ptr || (psel == PS_X);
            end
            AM_PREDEC: begin
                wb_val  = base - 16'd1;
                ea      = wb_val;
                wb_en   = !bad_ptr;
                illegal = bad_ptr;
            end
            AM_POSTINC: begin
                wb_val  = base + 16'd1;
                ea      = base;
                wb_en   = !bad_ptr;
                illegal = bad_ptr;
            end
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpr_region_dec.sv
module gpr_region_dec
    import gpr_pkg::*;
(
    input  logic [AW-1:0] ea,
    output logic [1:0]    region
);
    always_comb begin
        if (ea < AW'(NREG))
            region = RG_FILE;
        else if (ea < IO_LIMIT)
            region = RG_IO;
        else
            region = RG_SRAM;
    end
endmodule

// File: rtl/gpr_addr_unit.sv
module gpr_addr_unit
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        rd_a_idx,
    output logic [7:0]        rd_a_data,
    input  logic [4:0]        rd_b_idx,
    output logic [7:0]        rd_b_data,
    input  logic              alu_we,
    input  logic [4:0]        alu_widx,
    input  logic [7:0]        alu_wdata,
    input  logic              acc_valid,
    input  logic [2:0]        acc_mode,
    input  logic [1:0]        acc_ptr,
    input  logic [5:0]        acc_disp,
    input  logic [15:0]       acc_imm,
    input  logic              acc_store,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic [15:0]       ea,
    output logic [1:0]        region,
    output logic              acc_illegal,
    output logic              collision,
    output logic [14:0]       pm_word,
    output logic              pm_hi
);
    rf_state_t st_d, st_q;

    logic [3:0][AW-1:0] pair_q;
    logic               wb_en;
    logic [AW-1:0]      wb_val;
    logic               gen_illegal;
    logic [IDXW-1:0]    wb_lo;
    logic               upd_go;
    logic               rf_hit;

    // pointer views of the three top pairs; slot 3 is unused
    generate
        for (genvar p = 0; p < 3; p++) begin : g_pair
            localparam logic [IDXW-1:0] LO = IDXW'(26 + 2*p);
            assign pair_q[p] = {st_q.gpr[LO+1], st_q.gpr[LO]};
        end
    endgenerate
    assign pair_q[3] = '0;

    gpr_addr_gen u_gen (
        .mode    (acc_mode),
        .psel    (acc_ptr),
        .disp    (acc_disp),
        .imm     (acc_imm),
        .ptr_x   (pair_q[0]),
        .ptr_y   (pair_q[1]),
        .ptr_z   (pair_q[2]),
        .ea      (ea),
        .wb_en   (wb_en),
        .wb_val  (wb_val),
        .illegal (gen_illegal)
    );

    gpr_region_dec u_dec (
        .ea     (ea),
        .region (region)
    );

    assign acc_illegal = acc_valid && gen_illegal;
    assign upd_go      = acc_valid && !gen_illegal && wb_en;
    assign rf_hit      = acc_valid && !gen_illegal && (region == RG_FILE);
    assign wb_lo       = X_LO + {acc_ptr[1:0], 1'b0};

    assign rd_a_data = st_q.gpr[rd_a_idx];
    assign rd_b_data = st_q.gpr[rd_b_idx];
    assign acc_rdata = rf_hit ? st_q.gpr[ea[IDXW-1:0]] : '0;
    assign pm_word   = pair_q[2][AW-1:1];
    assign pm_hi     = pair_q[2][0];

    assign collision = upd_go && alu_we && (alu_widx[IDXW-1:1] == wb_lo[IDXW-1:1]);

    // next-state: lowest priority first, so later assignments win
    always_comb begin
        st_d = st_q;
        if (alu_we)
            st_d.gpr[alu_widx] = alu_wdata;
        if (rf_hit && acc_store)
            st_d.gpr[ea[IDXW-1:0]] = acc_wdata;
        if (upd_go) begin
            st_d.gpr[wb_lo]      = wb_val[7:0];
            st_d.gpr[wb_lo + 1'b1] = wb_val[15:8];
        end
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: reset leaves every register at zero
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    // R4: a post-increment leaves the pair one above its old value
    a_r4_postinc_step: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_illegal && acc_mode == AM_POSTINC)
        |=> (pair_q[$past(acc_ptr)] == $past(pair_q[acc_ptr]) + 16'd1));

    // R5: an illegal request with no ALU write leaves all registers alone
    a_r5_illegal_inert: assert property (@(posedge clk) disable iff (rst)
        (acc_illegal && !alu_we) |=> $stable(st_q));

    // R8: on a collision the pair holds the pointer result, not the ALU data
    a_r8_ptr_wins: assert property (@(posedge clk) disable iff (rst)
        collision |=> (pair_q[$past(acc_ptr)] == $past(wb_val)));

    // R6: the region code is one of the three defined values
    a_r6_region_code: assert property (@(posedge clk) disable iff (rst)
        region != 2'd3);
endmodule

// File: tb/gpr_addr_unit_bench.sv
module gpr_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, alu_widx;
    logic [7:0]  rd_a_data, rd_b_data, alu_wdata, acc_wdata, acc_rdata;
    logic        alu_we, acc_valid, acc_store, acc_illegal, collision, pm_hi;
    logic [2:0]  acc_mode;
    logic [1:0]  acc_ptr, region;
    logic [5:0]  acc_disp;
    logic [15:0] acc_imm, ea;
    logic [14:0] pm_word;

    int vec_cnt = 0;
    int err_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpr_addr_unit u_gpr_addr_unit (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
        .acc_valid(acc_valid), .acc_mode(acc_mode), .acc_ptr(acc_ptr),
        .acc_disp(acc_disp), .acc_imm(acc_imm), .acc_store(acc_store),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ea(ea),
        .region(region), .acc_illegal(acc_illegal), .collision(collision),
        .pm_word(pm_word), .pm_hi(pm_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_we = 0; alu_widx = 0; alu_wdata = 0;
        acc_valid = 0; acc_mode = 0; acc_ptr = 0; acc_disp = 0;
        acc_imm = 0; acc_store = 0; acc_wdata = 0;
    endtask

    // advance one clock edge, ending at the next falling edge with inputs idle
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic alu_wr(input logic [4:0] idx, input logic [7:0] val);
        alu_we = 1; alu_widx = idx; alu_wdata = val;
        step();
    endtask

    task automatic set_pair(input logic [4:0] lo, input logic [15:0] val);
        alu_wr(lo, val[7:0]);
        alu_wr(lo + 5'd1, val[15:8]);
    endtask

    task automatic rd_pair(input logic [4:0] lo, output logic [15:0] val);
        rd_a_idx = lo; rd_b_idx = lo + 5'd1;
        #1 val = {rd_b_data, rd_a_data};
    endtask

    task automatic rd_reg(input logic [4:0] idx, output logic [7:0] val);
        rd_a_idx = idx;
        #1 val = rd_a_data;
    endtask

    task automatic access(input logic [2:0] m, input logic [1:0] p, input logic [5:0] d,
                          input logic [15:0] im, input logic st, input logic [7:0] wd);
        acc_valid = 1; acc_mode = m; acc_ptr = p; acc_disp = d;
        acc_imm = im; acc_store = st; acc_wdata = wd;
        #2;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1; idle();
        step(); step();
        rst = 0;
        for (int i = 0; i < 32; i += 7) begin
            rd_reg(5'(i), v);
            chk("R1 reset clears register", v, 8'h00);
        end
        rd_reg(5'd31, v);
        chk("R1 reset clears r31", v, 8'h00);
    endtask

    task automatic t_alu_rw();
        alu_wr(5'd5, 8'hA5);
        alu_wr(5'd17, 8'h3C);
        rd_a_idx = 5'd5; rd_b_idx = 5'd17; #1;
        chk("R2 port A read", rd_a_data, 8'hA5);
        chk("R2 port B read", rd_b_data, 8'h3C);
    endtask

    task automatic t_direct_region();
        access(3'd0, 2'd0, 6'd0, 16'h1234, 0, 0);
        chk("R3 direct ea", ea, 16'h1234);
        chk("R6 sram region", region, 2'd2);
        acc_imm = 16'h005F; #1;
        chk("R6 io top", region, 2'd1);
        acc_imm = 16'h0020; #1;
        chk("R6 io bottom", region, 2'd1);
        acc_imm = 16'h001F; #1;
        chk("R6 regfile top", region, 2'd0);
        acc_imm = 16'h0060; #1;
        chk("R6 sram bottom", region, 2'd2);
        step();
    endtask

    task automatic t_indirect_disp();
        set_pair(5'd28, 16'h0100);
        access(3'd1, 2'd1, 6'd0, 16'h0, 0, 0);
        chk("R3 indirect Y ea", ea, 16'h0100);
        acc_mode = 3'd2; acc_disp = 6'd63; #1;
        chk("R3 disp Y+63 ea", ea, 16'h013F);
        chk("R3 disp Y legal", acc_illegal, 1'b0);
        step();
    endtask

    task automatic t_incdec();
        logic [15:0] v;
        set_pair(5'd26, 16'hFFFF);
        access(3'd4, 2'd0, 6'd0, 16'h0, 0, 0);
        chk("R4 postinc uses old X", ea, 16'hFFFF);
        step();
        rd_pair(5'd26, v);
        chk("R4 postinc wraps X", v, 16'h0000);
        set_pair(5'd30, 16'h0000);
        access(3'd3, 2'd2, 6'd0, 16'h0, 0, 0);
        chk("R4 predec uses new Z", ea, 16'hFFFF);
        step();
        rd_pair(5'd30, v);
        chk("R4 predec wraps Z", v, 16'hFFFF);
    endtask

    task automatic t_illegal();
        logic [15:0] v;
        set_pair(5'd26, 16'h0040);
        access(3'd2, 2'd0, 6'd5, 16'h0, 1, 8'h99);
        chk("R5 disp with X flagged", acc_illegal, 1'b1);
        step();
        rd_pair(5'd26, v);
        chk("R5 X unchanged after illegal", v, 16'h0040);
        access(3'd4, 2'd3, 6'd0, 16'h0, 0, 0);
        chk("R5 pointer code 3 flagged", acc_illegal, 1'b1);
        step();
        access(3'd6, 2'd0, 6'd0, 16'h0, 0, 0);
        chk("R5 mode 6 flagged", acc_illegal, 1'b1);
        step();
        rd_pair(5'd26, v);
        chk("R5 X unchanged after bad mode", v, 16'h0040);
    endtask

    task automatic t_rf_route();
        logic [7:0] v;
        alu_wr(5'd3, 8'h77);
        access(3'd0, 2'd0, 6'd0, 16'h0003, 0, 0);
        chk("R7 load from register file", acc_rdata, 8'h77);
        step();
        access(3'd0, 2'd0, 6'd0, 16'h0009, 1, 8'h5A);
        step();
        rd_reg(5'd9, v);
        chk("R7 store into r9", v, 8'h5A);
        access(3'd0, 2'd0, 6'd0, 16'h0200, 1, 8'hC3);
        chk("R7 sram load gives zero", acc_rdata, 8'h00);
        step();
        rd_reg(5'd0, v);
        chk("R7 sram store leaves r0", v, 8'h00);
        // store and ALU write to one register: store wins
        access(3'd0, 2'd0, 6'd0, 16'h000C, 1, 8'h11);
        alu_we = 1; alu_widx = 5'd12; alu_wdata = 8'h22;
        #1 chk("R8 no flag for store vs ALU", collision, 1'b0);
        step();
        rd_reg(5'd12, v);
        chk("R8 store beats ALU", v, 8'h11);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        set_pair(5'd26, 16'h00FF);
        access(3'd4, 2'd0, 6'd0, 16'h0, 0, 0);
        alu_we = 1; alu_widx = 5'd27; alu_wdata = 8'hEE;
        #1 chk("R8 collision flagged", collision, 1'b1);
        step();
        rd_pair(5'd26, v);
        chk("R8 pointer beats ALU", v, 16'h0100);
        alu_wr(5'd20, 8'h44);
        #1 chk("R8 no collision on plain write", collision, 1'b0);
    endtask

    task automatic t_pm();
        set_pair(5'd30, 16'h1235);
        #1;
        chk("R9 word address", pm_word, 15'h091A);
        chk("R9 high byte select", pm_hi, 1'b1);
        alu_wr(5'd30, 8'h34);
        #1 chk("R9 low byte select", pm_hi, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            err_cnt++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
            $finish;
        end
    end

    initial begin
        rd_a_idx = 0; rd_b_idx = 0; rst = 1; idle();
        @(negedge clk);
        t_reset();
        t_alu_rw();
        t_direct_region();
        t_indirect_disp();
        t_incdec();
        t_illegal();
        t_rf_route();
        t_collision();
        t_pm();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end
endmodule